// File: doc/BRIEF.md
# One-Wire Bit Slot Engine

This block produces the single-bit time slots that a one-wire master uses on an open-drain line. It never drives the line high. It either pulls the line low through `busDriveLow` or lets the external pull-up resistor raise it. A higher layer requests one slot at a time: write a one, write a zero, or read a bit. The request also picks regular or overdrive timing. The engine runs the low phase, the release phase and the recovery gap. It then reports completion with a one-cycle `done` pulse. For a read slot, it first stores the level the slave presented at a fixed sample point.

Every phase is measured in timing ticks. With the default values, a tick is half a microsecond. When `CYCLES_PER_TICK` is non-zero, an internal divider makes the ticks from the clock. When it is zero, the ticks come from the `tickIn` strobe. All phase lengths, for both speeds, are tick-count parameters.

Top module: `onewire_slot_engine`

## Requirements
- R1: After reset, `busDriveLow`, `busy`, `done` and `rxBit` are all 0.
- R2: `cmdOp` is decoded as follows: bit 1 set means a read slot; otherwise bit 0 gives the value written (00 = write zero, 01 = write one). A command is accepted on a clock edge where `cmdValid` is high and `busy` is low. `busy` then stays high for exactly (slot + recovery) ticks of the selected speed.
- R3: A write-one slot holds `busDriveLow` high for exactly the short-low tick count of its speed, starting at acceptance. It then releases the line for the rest of the slot.
- R4: A write-zero slot holds `busDriveLow` high for exactly the long-low tick count of its speed, starting at acceptance.
- R5: A read slot drives the line low for the short-low tick count and then releases it. It samples the line, after a two-flop synchronizer, when the tick count since acceptance reaches the sample point. `rxBit` then holds the sampled level (1 = line high).
- R6: The line stays released for the whole recovery gap that follows each slot. `busDriveLow` is never high while `busy` is low.
- R7: `done` is a single-cycle pulse. It rises on the same edge on which `busy` falls, and there is exactly one pulse per accepted command.
- R8: A `cmdValid` that arrives while `busy` is high is ignored. It neither changes the running slot nor starts a slot afterwards.
- R9: The speed class is captured at acceptance. Changing `speedSel` during a slot does not alter that slot's timing.
- R10: Write slots leave `rxBit` unchanged.
- R11: With a non-zero `CYCLES_PER_TICK`, the tick divider restarts at each acceptance. Every tick-count phase therefore lasts exactly `CYCLES_PER_TICK` clock cycles per tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Slot request strobe |
| cmdOp | input | 2 | Slot kind: 00 write zero, 01 write one, 1x read |
| speedSel | input | 1 | 0 regular timing, 1 overdrive timing |
| tickIn | input | 1 | External tick strobe, used when `CYCLES_PER_TICK` is 0 |
| busIn | input | 1 | Sensed line level (asynchronous) |
| busDriveLow | output | 1 | Pull the line low when 1, release when 0 |
| busy | output | 1 | Slot or recovery in progress |
| done | output | 1 | One-cycle pulse at the end of recovery |
| rxBit | output | 1 | Level sampled in the most recent read slot |

## Verification
The bench sets `CYCLES_PER_TICK` to 2 and keeps the default tick tables for both speeds. This shortens a regular slot to a few hundred cycles while still exercising the divider restart. It also makes every phase length an exact, even number of cycles that can be counted at the ports. A model slave answers read slots on both sides of the sample point. This makes an early or late capture, or a missing synchronizer stage, show up as a wrong `rxBit`. Changing the speed and sending extra requests in the middle of a slot, under both speed classes, exercises the capture-at-acceptance and ignore-while-busy behaviour.

// File: rtl/onewire_slot_pkg.sv
package onewire_slot_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SLOT    = 2'd1,
    PH_RECOVER = 2'd2
  } phase_t;

  // control -> datapath
  typedef struct packed {
    logic loadCmd;
    logic clrCount;
    logic runTimer;
    logic inSlot;
  } slot_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic slotEnd;
    logic recoverEnd;
  } slot_event_t;

endpackage

// File: rtl/onewire_slot_datapath.sv
module onewire_slot_datapath
  import onewire_slot_pkg::*;
#(
  parameter int CYCLES_PER_TICK = 100,
  parameter int REG_LOW1_T      = 12,
  parameter int REG_LOW0_T      = 120,
  parameter int REG_SAMPLE_T    = 28,
  parameter int REG_SLOT_T      = 140,
  parameter int REG_RECOVER_T   = 2,
  parameter int OD_LOW1_T       = 2,
  parameter int OD_LOW0_T       = 15,
  parameter int OD_SAMPLE_T     = 4,
  parameter int OD_SLOT_T       = 20,
  parameter int OD_RECOVER_T    = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  slot_strobe_t strobe,
  input  logic [1:0]   cmdOp,
  input  logic         speedSel,
  input  logic         tickIn,
  input  logic         busIn,
  output slot_event_t  evt,
  output logic         driveLow,
  output logic         rxBit
);

  localparam int MAX_T  = (REG_SLOT_T > REG_RECOVER_T) ? REG_SLOT_T : REG_RECOVER_T;
  localparam int TICK_W = $clog2(MAX_T + 1) + 1;

  logic               isRead;
  logic               writeVal;
  logic               odSel;
  logic [1:0]         syncQ;
  logic               tick;
  logic [TICK_W-1:0]  tickCnt;
  logic [TICK_W-1:0]  lowLen;
  logic [TICK_W-1:0]  sampleAt;
  logic [TICK_W-1:0]  slotLen;
  logic [TICK_W-1:0]  recLen;
  logic               sampleHit;

  // command latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      isRead   <= 1'b0;
      writeVal <= 1'b0;
      odSel    <= 1'b0;
    end else if (strobe.loadCmd) begin
      isRead   <= cmdOp[1];
      writeVal <= cmdOp[0];
      odSel    <= speedSel;
    end
  end

  // two-flop synchronizer on the sensed line
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], busIn};
  end

  // tick source: internal divider or external strobe
  generate
    if (CYCLES_PER_TICK > 0) begin : gen_divider
      localparam int DIV_W = $clog2(CYCLES_PER_TICK + 1);
      logic [DIV_W-1:0] divCnt;
      logic             unusedTickIn;
      assign unusedTickIn = tickIn;
      assign tick = strobe.runTimer && (divCnt == DIV_W'(CYCLES_PER_TICK - 1));
      always_ff @(posedge clk) begin
        if (!rstN || !strobe.runTimer) divCnt <= '0;
        else if (tick)                 divCnt <= '0;
        else                           divCnt <= divCnt + 1'b1;
      end
    end else begin : gen_external
      assign tick = strobe.runTimer && tickIn;
    end
  endgenerate

  // timing table selected by latched speed
  always_comb begin
    if (odSel) begin
      lowLen   = (isRead || writeVal) ? TICK_W'(OD_LOW1_T) : TICK_W'(OD_LOW0_T);
      sampleAt = TICK_W'(OD_SAMPLE_T);
      slotLen  = TICK_W'(OD_SLOT_T);
      recLen   = TICK_W'(OD_RECOVER_T);
    end else begin
      lowLen   = (isRead || writeVal) ? TICK_W'(REG_LOW1_T) : TICK_W'(REG_LOW0_T);
      sampleAt = TICK_W'(REG_SAMPLE_T);
      slotLen  = TICK_W'(REG_SLOT_T);
      recLen   = TICK_W'(REG_RECOVER_T);
    end
  end

  // phase tick counter
  always_ff @(posedge clk) begin
    if (!rstN)                tickCnt <= '0;
    else if (strobe.clrCount) tickCnt <= '0;
    else if (tick)            tickCnt <= tickCnt + 1'b1;
  end

  assign evt.slotEnd    = tick && strobe.inSlot  && (tickCnt == slotLen - 1'b1);
  assign evt.recoverEnd = tick && !strobe.inSlot && (tickCnt == recLen - 1'b1);
  assign sampleHit      = tick && strobe.inSlot && isRead && (tickCnt == sampleAt - 1'b1);
  assign driveLow       = strobe.inSlot && (tickCnt < lowLen);

  always_ff @(posedge clk) begin
    if (!rstN)          rxBit <= 1'b0;
    else if (sampleHit) rxBit <= syncQ[1];
  end

  // the master must already have released the line when the read sample is taken
  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    sampleHit |-> !driveLow); // R5

  // counter never passes the slot length inside a slot
  AST_COUNT_IN_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inSlot |-> (tickCnt < slotLen)); // R2

endmodule

// File: rtl/onewire_slot_ctrl.sv
module onewire_slot_ctrl
  import onewire_slot_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  slot_event_t  evt,
  output slot_strobe_t strobe,
  output logic         busy,
  output logic         done
);

  phase_t phase;

  always_comb begin
    strobe          = '0;
    strobe.runTimer = (phase != PH_IDLE);
    strobe.inSlot   = (phase == PH_SLOT);
    strobe.loadCmd  = (phase == PH_IDLE) && cmdValid;
    strobe.clrCount = strobe.loadCmd || ((phase == PH_SLOT) && evt.slotEnd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE:    if (cmdValid) phase <= PH_SLOT;
        PH_SLOT:    if (evt.slotEnd) phase <= PH_RECOVER;
        PH_RECOVER: if (evt.recoverEnd) begin
                      phase <= PH_IDLE;
                      done  <= 1'b1;
                    end
        default:    phase <= PH_IDLE;
      endcase
    end
  end

  assign busy = (phase != PH_IDLE);

  AST_DONE_AFTER_RECOVER: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(phase == PH_RECOVER)); // R7

  AST_START_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdValid)); // R2

endmodule

// File: rtl/onewire_slot_engine.sv
module onewire_slot_engine
  import onewire_slot_pkg::*;
#(
  parameter int CYCLES_PER_TICK = 100,
  parameter int REG_LOW1_T      = 12,
  parameter int REG_LOW0_T      = 120,
  parameter int REG_SAMPLE_T    = 28,
  parameter int REG_SLOT_T      = 140,
  parameter int REG_RECOVER_T   = 2,
  parameter int OD_LOW1_T       = 2,
  parameter int OD_LOW0_T       = 15,
  parameter int OD_SAMPLE_T     = 4,
  parameter int OD_SLOT_T       = 20,
  parameter int OD_RECOVER_T    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       speedSel,
  input  logic       tickIn,
  input  logic       busIn,
  output logic       busDriveLow,
  output logic       busy,
  output logic       done,
  output logic       rxBit
);

  slot_strobe_t strobe;
  slot_event_t  evt;

  onewire_slot_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .evt      (evt),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  onewire_slot_datapath #(
    .CYCLES_PER_TICK (CYCLES_PER_TICK),
    .REG_LOW1_T      (REG_LOW1_T),
    .REG_LOW0_T      (REG_LOW0_T),
    .REG_SAMPLE_T    (REG_SAMPLE_T),
    .REG_SLOT_T      (REG_SLOT_T),
    .REG_RECOVER_T   (REG_RECOVER_T),
    .OD_LOW1_T       (OD_LOW1_T),
    .OD_LOW0_T       (OD_LOW0_T),
    .OD_SAMPLE_T     (OD_SAMPLE_T),
    .OD_SLOT_T       (OD_SLOT_T),
    .OD_RECOVER_T    (OD_RECOVER_T)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdOp    (cmdOp),
    .speedSel (speedSel),
    .tickIn   (tickIn),
    .busIn    (busIn),
    .evt      (evt),
    .driveLow (busDriveLow),
    .rxBit    (rxBit)
  );

  AST_RELEASED_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busDriveLow); // R6

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy))); // R7

  AST_RX_ONLY_IN_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxBit) |-> $past(busy)); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

endmodule

// File: tb/onewire_slot_engine_test.sv
module onewire_slot_engine_test;

  localparam int CPT = 2;
  localparam int RL1 = 12, RL0 = 120, RSM = 28, RSL = 140, RRC = 2;
  localparam int OL1 = 2,  OL0 = 15,  OSM = 4,  OSL = 20,  ORC = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic       speedSel = 1'b0;
  logic       tickIn = 1'b0;
  logic       slaveLow = 1'b0;
  logic       busIn;
  logic       busDriveLow, busy, done, rxBit;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic expRx = 1'b0;

  assign busIn = !(busDriveLow || slaveLow);

  always #2.5 clk = ~clk;

  onewire_slot_engine #(.CYCLES_PER_TICK(CPT)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .speedSel(speedSel), .tickIn(tickIn), .busIn(busIn),
    .busDriveLow(busDriveLow), .busy(busy), .done(done), .rxBit(rxBit)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int expLow(input logic [1:0] op, input logic od);
    if (op[1] || op[0]) return (od ? OL1 : RL1) * CPT;
    return (od ? OL0 : RL0) * CPT;
  endfunction

  function automatic int expBusy(input logic od);
    return od ? (OSL + ORC) * CPT : (RSL + RRC) * CPT;
  endfunction

  function automatic int expSample(input logic od);
    return (od ? OSM : RSM) * CPT;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one slot; disturb => extra request and speed flip mid-slot
  task automatic runSlot(input logic [1:0] op, input logic od,
                         input logic slaveBit, input bit disturb);
    int lowCnt = 0;
    int busyCnt = 0;
    int lastLow = 0;
    int i = 0;
    string lowReq;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; speedSel = od;
    @(negedge clk);
    cmdValid = 1'b0;
    speedSel = $urandom_range(0, 1);
    while (busy) begin
      i++;
      busyCnt++;
      if (busDriveLow) begin lowCnt++; lastLow = i; end
      slaveLow = op[1] && !slaveBit && (i >= 1) && (i <= expSample(od) + 6 * CPT);
      if (disturb && i == 5) begin
        cmdValid = 1'b1; cmdOp = ~op; speedSel = !od;
      end
      if (disturb && i == 6) cmdValid = 1'b0;
      @(negedge clk);
    end
    slaveLow = 1'b0;
    lowReq = op[1] ? "R5 read low" : (op[0] ? "R3 write-one low" : "R4 write-zero low");
    check(lowReq, lowCnt, expLow(op, od));
    check("R6 low contiguous from start", lastLow, expLow(op, od));
    check(disturb ? "R9 R8 busy length" : "R2 R11 busy length", busyCnt, expBusy(od));
    check("R7 done at busy fall", int'(done), 1);
    if (op[1]) expRx = slaveBit;
    check(op[1] ? "R5 read bit" : "R10 rxBit kept", int'(rxBit), int'(expRx));
    @(negedge clk);
    check("R7 done single", int'(done), 0);
    check("R8 no queued slot", int'(busy), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check("R1 reset drive", int'(busDriveLow), 0);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset done", int'(done), 0);
    check("R1 reset rxBit", int'(rxBit), 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed: every kind at both speeds
    for (int sp = 0; sp < 2; sp++) begin
      runSlot(2'b01, sp[0], 1'b0, 0);
      runSlot(2'b00, sp[0], 1'b0, 0);
      runSlot(2'b10, sp[0], 1'b0, 0);
      runSlot(2'b11, sp[0], 1'b1, 0);
      runSlot(2'b00, sp[0], 1'b0, 0); // R10 after read-one
      runSlot(2'b10, sp[0], 1'b0, 1); // R8 R9 disturbance
      runSlot(2'b01, sp[0], 1'b1, 1);
    end

    // random mix
    for (int n = 0; n < 40; n++) begin
      runSlot(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), bit'($urandom_range(0, 3) == 0));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule